// File: doc/BRIEF.md
# Asynchronous Memory Bus Timing Monitor

A passive observer for an asynchronous static-memory style bus. It samples chip select, write strobe, the two byte enables, the low-power pin, the address and the data lines on a fast free-running clock. From these samples it measures time intervals in clock ticks and compares them against limits set by parameters. It never drives the bus.

A write is taken to last while chip select and write strobe are both low and at least one byte enable is low. It therefore begins at the later of the two strobe falls and ends at the earlier of their rises. Each rule that is broken sets its own sticky flag and adds to a saturating error counter. A synchronous clear input resets both. Bus activity is ignored while the low-power pin is low or chip select is high.

Top module: `sram_timing_monitor`

## Requirements
- R1: After reset, `err_flags` and `err_count` are zero. A high `clr` at a clock edge zeroes both at that edge.
- R2: A write window shorter than `T_WP_MIN` ticks sets `err_flags[0]`. The window is open while `cs_n`, `we_n` and at least one of `lb_n`/`ub_n` are low.
- R3: If data last changed fewer than `T_DW_MIN` ticks before the window closes, `err_flags[1]` is set.
- R4: If chip select went low fewer than `T_CW_MIN` ticks before the window closes, `err_flags[2]` is set.
- R5: If the address last changed fewer than `T_AW_MIN` ticks before the window closes, `err_flags[3]` is set.
- R6: If the address last changed fewer than `T_AS_MIN` ticks before the window opens, `err_flags[4]` is set. With the default of 0 this rule never fires.
- R7: An address change while the write window is open sets `err_flags[5]`.
- R8: `err_flags[6]` is set when two successive address changes under one chip select are fewer than `T_CYC_MIN` ticks apart. The first change after chip select falls is not measured.
- R9: `err_flags[7]` is set, once per cycle, when the address is held under an active chip select for `T_CYC_MAX` ticks.
- R10: `err_flags[8]` is set once when a run of cycles, each no longer than `T_FAST` ticks, lasts `T_BURST_MAX` ticks. A cycle longer than `T_FAST` ends the run, and so does releasing chip select.
- R11: Every rule event adds one to `err_count`. The count saturates at its maximum. Flags stay set until `clr`.
- R12: While `zz_n` is low, or `cs_n` is high, no rule event is raised.
- R13: A write strobe with both byte enables high opens no window and raises no write-rule event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of flags and count |
| cs_n | input | 1 | Observed chip select, active low |
| we_n | input | 1 | Observed write strobe, active low |
| lb_n | input | 1 | Observed lower byte enable, active low |
| ub_n | input | 1 | Observed upper byte enable, active low |
| zz_n | input | 1 | Observed low-power pin, low means asleep |
| addr | input | AW | Observed address |
| data | input | DW | Observed data lines |
| err_flags | output | NRULE | Sticky per-rule violation flags |
| err_count | output | CNT_W | Saturating total of rule events |

## Verification
A bus change passes through one input register and then one history register. Each rule event is registered into the flags and the counter on the second clock edge after the change. Every scenario task leaves the bus idle for at least six clock periods after its final strobe edge, and only then samples the outputs on a falling edge, well after that result has settled. The interval tests keep a margin of several ticks from each limit, because there is a one-tick uncertainty in where the edges are sampled. The clear test checks the outputs on the falling edge right after the single edge at which `clr` is high.

// File: rtl/sram_timing_monitor.sv
module sram_timing_monitor #(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int CW          = 16,
  parameter int CNT_W       = 16,
  parameter int T_WP_MIN    = 13,
  parameter int T_DW_MIN    = 5,
  parameter int T_CW_MIN    = 15,
  parameter int T_AW_MIN    = 15,
  parameter int T_AS_MIN    = 0,
  parameter int T_CYC_MIN   = 18,
  parameter int T_CYC_MAX   = 10000,
  parameter int T_FAST      = 25,
  parameter int T_BURST_MAX = 10000,
  localparam int NRULE      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             lb_n,
  input  logic             ub_n,
  input  logic             zz_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  output logic [NRULE-1:0] err_flags,
  output logic [CNT_W-1:0] err_count
);

  localparam int EVW = $clog2(NRULE + 1);
  localparam logic [CW-1:0] L_WP    = CW'(T_WP_MIN);
  localparam logic [CW-1:0] L_DW    = CW'(T_DW_MIN);
  localparam logic [CW-1:0] L_CW    = CW'(T_CW_MIN);
  localparam logic [CW-1:0] L_AW    = CW'(T_AW_MIN);
  localparam logic [CW-1:0] L_CMIN  = CW'(T_CYC_MIN);
  localparam logic [CW-1:0] L_CMAX  = CW'(T_CYC_MAX);
  localparam logic [CW-1:0] L_FAST  = CW'(T_FAST);
  localparam logic [CW-1:0] L_BURST = CW'(T_BURST_MAX);

  function automatic logic [CW-1:0] sinc(input logic [CW-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  logic          s_cs_n, s_we_n, s_byte, s_zz_n, p_zz_n, win_p;
  logic [AW-1:0] s_addr, p_addr;
  logic [DW-1:0] s_data, p_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs_n <= 1'b1;
      s_we_n <= 1'b1;
      s_byte <= 1'b0;
      s_zz_n <= 1'b0;
      p_zz_n <= 1'b0;
      s_addr <= '0;
      p_addr <= '0;
      s_data <= '0;
      p_data <= '0;
      win_p  <= 1'b0;
    end else begin
      s_cs_n <= cs_n;
      s_we_n <= we_n;
      s_byte <= ~lb_n | ~ub_n;
      s_zz_n <= zz_n;
      p_zz_n <= s_zz_n;
      s_addr <= addr;
      p_addr <= s_addr;
      s_data <= data;
      p_data <= s_data;
      win_p  <= win_s;
    end
  end

  logic act, win_s, start, fin, a_chg, d_chg;
  assign act   = s_zz_n & ~s_cs_n;
  assign win_s = act & ~s_we_n & s_byte;
  assign start = win_s & ~win_p;
  assign fin   = win_p & ~win_s & s_zz_n;
  assign a_chg = s_addr != p_addr;
  assign d_chg = s_data != p_data;

  logic [CW-1:0] wp_cnt, cs_age, a_age, d_age, cyc_cnt, run_cnt;
  logic          cyc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_cnt  <= '0;
      cs_age  <= '0;
      a_age   <= '0;
      d_age   <= '0;
      cyc_cnt <= '0;
      cyc_ok  <= 1'b0;
      run_cnt <= '0;
    end else begin
      wp_cnt  <= start ? CW'(1) : (win_s ? sinc(wp_cnt) : wp_cnt);
      cs_age  <= act ? sinc(cs_age) : '0;
      a_age   <= a_chg ? '0 : sinc(a_age);
      d_age   <= d_chg ? '0 : sinc(d_age);
      cyc_cnt <= (!act || a_chg) ? '0 : sinc(cyc_cnt);
      cyc_ok  <= !act ? 1'b0 : (a_chg ? 1'b1 : cyc_ok);
      run_cnt <= (!act || cyc_cnt > L_FAST) ? '0 : sinc(run_cnt);
    end
  end

  logic [NRULE-1:0] ev;
  logic             ev_as;

  if (T_AS_MIN > 0) begin : g_as
    localparam logic [CW-1:0] L_AS = CW'(T_AS_MIN);
    assign ev_as = start & (a_age < L_AS);
  end else begin : g_noas
    assign ev_as = 1'b0;
  end

  assign ev[0] = fin & (wp_cnt < L_WP);
  assign ev[1] = fin & (d_age < L_DW);
  assign ev[2] = fin & (cs_age < L_CW);
  assign ev[3] = fin & (a_age < L_AW);
  assign ev[4] = ev_as;
  assign ev[5] = win_s & win_p & a_chg;
  assign ev[6] = act & a_chg & cyc_ok & (cyc_cnt < L_CMIN);
  assign ev[7] = act & ~a_chg & (cyc_cnt == L_CMAX);
  assign ev[8] = act & (run_cnt == L_BURST);

  logic [EVW-1:0] n_ev;
  always_comb begin
    n_ev = '0;
    for (int i = 0; i < NRULE; i++) n_ev = n_ev + EVW'(ev[i]);
  end

  logic [CNT_W:0] sum;
  assign sum = {1'b0, err_count} + (CNT_W+1)'(n_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_count <= '0;
    end else if (clr) begin
      err_flags <= '0;
      err_count <= '0;
    end else begin
      err_flags <= err_flags | ev;
      err_count <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
  end

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_flags == '0 && err_count == '0));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  assert_count_mono_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> err_count >= $past(err_count));

  assert_flag_counted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != '0) |-> (err_count != '0));

  assert_quiet_asleep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !s_zz_n && !p_zz_n) |=> err_count == $past(err_count));

endmodule

// File: tb/tb_sram_timing_monitor.sv
`timescale 1ns/1ps
module tb_sram_timing_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        cs_n = 1'b1, we_n = 1'b1, lb_n = 1'b0, ub_n = 1'b0, zz_n = 1'b1;
  logic [19:0] addr = 20'h00010;
  logic [15:0] data = 16'h1234;
  logic [8:0]  err_flags;
  logic [3:0]  err_count;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sram_timing_monitor #(
    .CNT_W(4), .T_WP_MIN(10), .T_DW_MIN(5), .T_CW_MIN(20), .T_AW_MIN(20),
    .T_AS_MIN(3), .T_CYC_MIN(15), .T_CYC_MAX(200), .T_FAST(20), .T_BURST_MAX(300)
  ) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .we_n(we_n),
    .lb_n(lb_n), .ub_n(ub_n), .zz_n(zz_n), .addr(addr), .data(data),
    .err_flags(err_flags), .err_count(err_count)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic outs(string req, int f, int c);
    chk({req, " flags"}, int'(err_flags), f);
    chk({req, " count"}, int'(err_count), c);
  endtask

  task automatic do_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic do_write(int cs_lead, int pulse, int dlead, int achg);
    @(negedge clk) addr = addr + 20'h100;
    repeat (20) @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < cs_lead + pulse; i++) begin
      if (i == cs_lead) we_n = 1'b0;
      if (i == cs_lead + pulse - dlead) data = data ^ 16'h5a5a;
      if (i == achg) addr = addr + 20'h1;
      @(negedge clk);
    end
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_seq(int n, int gap);
    @(negedge clk) cs_n = 1'b0;
    repeat (5) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      addr = addr + 20'h1;
      repeat (gap) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_good_write();
    do_clr(); do_write(20, 20, 10, -1); outs("R2 clean write", 0, 0);
  endtask
  task automatic t_short_pulse();
    do_clr(); do_write(20, 4, 10, -1); outs("R2 short window", 9'h001, 1);
  endtask
  task automatic t_data_setup();
    do_clr(); do_write(20, 20, 2, -1); outs("R3 late data", 9'h002, 1);
  endtask
  task automatic t_cs_end();
    do_clr(); do_write(0, 12, 8, -1); outs("R4 chip select late", 9'h004, 1);
  endtask
  task automatic t_addr_end();
    do_clr(); do_write(25, 12, 10, 20); outs("R5 address late", 9'h008, 1);
  endtask
  task automatic t_addr_setup();
    do_clr(); do_write(25, 25, 10, 24); outs("R6 address setup", 9'h010, 1);
  endtask
  task automatic t_addr_move();
    do_clr(); do_write(25, 25, 10, 35); outs("R7 address moved in window", 9'h028, 2);
  endtask
  task automatic t_read_fast();
    do_clr(); read_seq(3, 8); outs("R8 short cycles", 9'h040, 2);
  endtask
  task automatic t_read_ok();
    do_clr(); read_seq(5, 18); outs("R8 legal cycles", 0, 0);
  endtask
  task automatic t_cycle_max();
    do_clr(); read_seq(1, 250); outs("R9 cycle too long", 9'h080, 1);
  endtask
  task automatic t_burst();
    do_clr(); read_seq(25, 17); outs("R10 long fast run", 9'h100, 1);
  endtask
  task automatic t_asleep();
    do_clr();
    @(negedge clk) zz_n = 1'b0;
    do_write(20, 4, 2, 22);
    read_seq(4, 3);
    outs("R12 low power", 0, 0);
    @(negedge clk) zz_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask
  task automatic t_deselected();
    do_clr();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk) addr = addr + 20'h1; we_n = ~we_n;
      @(negedge clk);
    end
    we_n = 1'b1;
    repeat (6) @(negedge clk);
    outs("R12 chip select high", 0, 0);
  endtask
  task automatic t_no_bytes();
    do_clr();
    @(negedge clk) begin lb_n = 1'b1; ub_n = 1'b1; end
    do_write(20, 4, 2, -1);
    outs("R13 no byte enable", 0, 0);
    @(negedge clk) begin lb_n = 1'b0; ub_n = 1'b0; end
  endtask
  task automatic t_saturate();
    do_clr();
    for (int k = 0; k < 20; k++) do_write(20, 4, 10, -1);
    outs("R11 saturation", 9'h001, 15);
  endtask
  task automatic t_clear();
    do_clr();
    outs("R1 clear", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    outs("R1 reset", 0, 0);
    t_good_write();
    t_short_pulse();
    t_data_setup();
    t_cs_end();
    t_addr_end();
    t_addr_setup();
    t_addr_move();
    t_read_fast();
    t_read_ok();
    t_cycle_max();
    t_burst();
    t_asleep();
    t_deselected();
    t_no_bytes();
    t_saturate();
    t_clear();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule